// File: doc/BRIEF.md
# Hidden Timing Configuration Window

This block sits beside the task-file decoder of a legacy ATA host port and holds that port's hidden timing configuration. It sees every byte or word access that falls within the first eight offsets of the port's I/O base. Most of the time it does nothing with them. A short unlock sequence makes the block claim those offsets for its own registers until a closing key is written. While the window is open, the offsets reach two timing register sets, a control register, a read-only strap register and a miscellaneous register.

Two drives can share the port. Each timing set holds one read-cycle byte and one write-cycle byte. The low bit of the miscellaneous register selects which set a timing access reaches, but the second set is reachable only after a separate enable write. A bit in the control register decides whether the two drives use separate sets or both use the first set. The block's outputs give the timing and miscellaneous values that apply to the drive picked by a select input, so the strobe generator can use them directly.

Top module: `cfg_window_top`

## Requirements
- R1: From a closed window, a word read at offset 1, a second word read at offset 1 and then a byte write of 0x03 at offset 2, issued as consecutive accesses, raise `win_open` in the cycle after the write.
- R2: While the window is closed, any access that is not the next step of the R1 sequence returns the detector to its start. After a wrong step, including a third word read at offset 1, the write of 0x03 alone does not open the window.
- R3: While the window is open, a byte write of 0x83 at offset 2 lowers `win_open` in the next cycle. A write of any other value at offset 2 leaves the window open.
- R4: While the window is closed, no access changes the timing, control or miscellaneous registers, and reads return `rd_hit`=0 and `rd_data`=0.
- R5: While the window is open, offset 0 is the read timing and offset 1 is the write timing of the addressed set, offset 3 is control and offset 6 is miscellaneous. A write of either size stores the data byte from the next cycle. A read returns the value in the same cycle with `rd_hit`=1. Offsets 2, 4 and 7 read with `rd_hit`=0.
- R6: Offset 5 reads as {7'b0, `strap_clk25`}, where 1 means a 25 MHz bus clock and 0 means 33 MHz. A write to offset 5 changes no register.
- R7: Once the second set is enabled, miscellaneous bit 0 = 0 addresses set A and bit 0 = 1 addresses set B.
- R8: A byte write of 0xC0 at offset 3 while the window is closed enables set B. Until that happens, timing accesses reach set A whatever the miscellaneous bit 0 holds.
- R9: Control bit 0 = 1 gives drive 0 set A and drive 1 set B (0x85, for example). Control bit 0 = 0 gives both drives set A.
- R10: `act_rd_tim`, `act_wr_tim` and `act_misc` follow `drive_sel` and the registers with no added cycle of delay.
- R11: After reset the window is closed, set B is disabled, both timing sets hold `RST_TIM` (default 0xFF, the slowest setting), and control and miscellaneous are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access happens this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_off | input | 3 | Offset from the port base |
| acc_wdata | input | 8 | Write data (low byte) |
| strap_clk25 | input | 1 | Board strap: 1 = 25 MHz bus clock |
| drive_sel | input | 1 | Drive whose active timing is shown |
| rd_data | output | 8 | Read data for a claimed read |
| rd_hit | output | 1 | The window claims this read |
| win_open | output | 1 | Configuration window is open |
| act_rd_tim | output | 8 | Read timing for the selected drive |
| act_wr_tim | output | 8 | Write timing for the selected drive |
| act_misc | output | 8 | Miscellaneous value in force |

## Verification
The embedded properties check on every cycle that the window opens only on the key write and closes on the closing key, and that a wrong step sends the detector back to its start. They also check that nothing writable changes while the window is closed or on a strap write, that set B stays frozen until it is enabled, and that a shared-set control steers both drives to set A. The bench scenarios alone can show that complete register values read back through the right set, that the strap pin value appears at offset 5, and that broken or over-long sequences fail to open the window across long random access streams.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;

    localparam int DATA_W   = 8;
    localparam int OFF_W    = 3;
    localparam int NUM_SETS = 2;

    localparam logic [OFF_W-1:0] OFF_RD_TIM = 3'd0;
    localparam logic [OFF_W-1:0] OFF_WR_TIM = 3'd1;
    localparam logic [OFF_W-1:0] OFF_KEY    = 3'd2;
    localparam logic [OFF_W-1:0] OFF_CTRL   = 3'd3;
    localparam logic [OFF_W-1:0] OFF_STRAP  = 3'd5;
    localparam logic [OFF_W-1:0] OFF_MISC   = 3'd6;
    localparam logic [OFF_W-1:0] OFF_PROBE  = 3'd1;

    localparam logic [DATA_W-1:0] KEY_OPEN    = 8'h03;
    localparam logic [DATA_W-1:0] KEY_CLOSE   = 8'h83;
    localparam logic [DATA_W-1:0] SETB_UNLOCK = 8'hC0;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ONE  = 2'd1,
        SQ_TWO  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] rd;
        logic [DATA_W-1:0] wr;
    } tim_set_t;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic              word;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] data;
    } bus_acc_t;

    function automatic logic is_probe_read(bus_acc_t a);
        return a.valid && !a.write && a.word && (a.off == OFF_PROBE);
    endfunction

    function automatic logic is_byte_wr(bus_acc_t a, logic [OFF_W-1:0] o,
                                        logic [DATA_W-1:0] v);
        return a.valid && a.write && !a.word && (a.off == o) && (a.data == v);
    endfunction

endpackage

// File: rtl/cfg_window_seq.sv
module cfg_window_seq
    import cfg_window_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_acc_t acc,
    output logic     win_open
);

    seq_state_e state;
    logic       probe_rd;
    logic       open_key;
    logic       close_key;

    assign probe_rd  = is_probe_read(acc);
    assign open_key  = is_byte_wr(acc, OFF_KEY, KEY_OPEN);
    assign close_key = is_byte_wr(acc, OFF_KEY, KEY_CLOSE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            win_open <= 1'b0;
        end else if (acc.valid) begin
            if (win_open) begin
                state <= SQ_IDLE;
                if (close_key) win_open <= 1'b0;
            end else begin
                unique case (state)
                    SQ_IDLE: state <= probe_rd ? SQ_ONE : SQ_IDLE;
                    SQ_ONE:  state <= probe_rd ? SQ_TWO : SQ_IDLE;
                    SQ_TWO: begin
                        state <= SQ_IDLE;
                        if (open_key) win_open <= 1'b1;
                    end
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end

    AST_OPEN_ON_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(win_open) |-> $past(open_key)); // R1

    AST_BREAK_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!win_open && acc.valid && state != SQ_IDLE && !probe_rd && !open_key)
        |=> (state == SQ_IDLE) && !win_open); // R2

    AST_CLOSE_ON_KEY: assert property (@(posedge clk) disable iff (rst)
        (win_open && close_key) |=> !win_open); // R3

    AST_OTHER_KEY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (win_open && !close_key) |=> win_open); // R3

endmodule

// File: rtl/cfg_window_regs.sv
module cfg_window_regs
    import cfg_window_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_TIM = 8'hFF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  bus_acc_t                   acc,
    input  logic                       win_open,
    input  logic                       strap_clk25,
    output tim_set_t [NUM_SETS-1:0]    sets,
    output logic [DATA_W-1:0]          ctrl,
    output logic [DATA_W-1:0]          misc,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       rd_hit
);

    localparam int IDX_W = $clog2(NUM_SETS);

    logic             setb_en;
    logic             wr_en;
    logic [IDX_W-1:0] idx;
    tim_set_t         cur;

    assign wr_en = win_open && acc.valid && acc.write;
    assign idx   = IDX_W'(setb_en & misc[0]);
    assign cur   = sets[idx];

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                sets[g] <= '{rd: RST_TIM, wr: RST_TIM};
            end else if (wr_en && (idx == IDX_W'(g))) begin
                if (acc.off == OFF_RD_TIM) sets[g].rd <= acc.data;
                if (acc.off == OFF_WR_TIM) sets[g].wr <= acc.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            misc    <= '0;
            setb_en <= 1'b0;
        end else begin
            if (wr_en && acc.off == OFF_CTRL) ctrl <= acc.data;
            if (wr_en && acc.off == OFF_MISC) misc <= acc.data;
            if (!win_open && is_byte_wr(acc, OFF_CTRL, SETB_UNLOCK))
                setb_en <= 1'b1;
        end
    end

    always_comb begin
        rd_hit  = 1'b0;
        rd_data = '0;
        if (win_open && acc.valid && !acc.write) begin
            rd_hit = 1'b1;
            unique case (acc.off)
                OFF_RD_TIM: rd_data = cur.rd;
                OFF_WR_TIM: rd_data = cur.wr;
                OFF_CTRL:   rd_data = ctrl;
                OFF_STRAP:  rd_data = {{(DATA_W-1){1'b0}}, strap_clk25};
                OFF_MISC:   rd_data = misc;
                default:    rd_hit  = 1'b0;
            endcase
        end
    end

    AST_CLOSED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !win_open |=> $stable(sets) && $stable(ctrl) && $stable(misc)); // R4

    AST_STRAP_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acc.off == OFF_STRAP)
        |=> $stable(sets) && $stable(ctrl) && $stable(misc)); // R6

    AST_SETB_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !setb_en |=> $stable(sets[1])); // R8

endmodule

// File: rtl/cfg_window_drive_mux.sv
module cfg_window_drive_mux
    import cfg_window_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  tim_set_t [NUM_SETS-1:0] sets,
    input  logic [DATA_W-1:0]       ctrl,
    input  logic [DATA_W-1:0]       misc,
    input  logic                    drive_sel,
    output logic [DATA_W-1:0]       act_rd_tim,
    output logic [DATA_W-1:0]       act_wr_tim,
    output logic [DATA_W-1:0]       act_misc
);

    logic     use_set;
    tim_set_t chosen;

    assign use_set    = ctrl[0] & drive_sel;
    assign chosen     = sets[use_set];
    assign act_rd_tim = chosen.rd;
    assign act_wr_tim = chosen.wr;
    assign act_misc   = misc;

    AST_SHARED_SET_A: assert property (@(posedge clk) disable iff (rst)
        !ctrl[0] |-> (act_rd_tim == sets[0].rd) && (act_wr_tim == sets[0].wr)); // R9

    AST_DRIVE1_SET_B: assert property (@(posedge clk) disable iff (rst)
        (ctrl[0] && drive_sel) |-> (act_rd_tim == sets[1].rd)); // R9

endmodule

// File: rtl/cfg_window_top.sv
module cfg_window_top
    import cfg_window_pkg::*;
#(
    parameter logic [7:0] RST_TIM = 8'hFF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic       acc_word,
    input  logic [2:0] acc_off,
    input  logic [7:0] acc_wdata,
    input  logic       strap_clk25,
    input  logic       drive_sel,
    output logic [7:0] rd_data,
    output logic       rd_hit,
    output logic       win_open,
    output logic [7:0] act_rd_tim,
    output logic [7:0] act_wr_tim,
    output logic [7:0] act_misc
);

    bus_acc_t                acc;
    tim_set_t [NUM_SETS-1:0] sets;
    logic [DATA_W-1:0]       ctrl;
    logic [DATA_W-1:0]       misc;

    assign acc = '{valid: acc_valid, write: acc_write, word: acc_word,
                   off: acc_off, data: acc_wdata};

    cfg_window_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .win_open (win_open)
    );

    cfg_window_regs #(.RST_TIM(RST_TIM)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .acc         (acc),
        .win_open    (win_open),
        .strap_clk25 (strap_clk25),
        .sets        (sets),
        .ctrl        (ctrl),
        .misc        (misc),
        .rd_data     (rd_data),
        .rd_hit      (rd_hit)
    );

    cfg_window_drive_mux u_mux (
        .clk        (clk),
        .rst        (rst),
        .sets       (sets),
        .ctrl       (ctrl),
        .misc       (misc),
        .drive_sel  (drive_sel),
        .act_rd_tim (act_rd_tim),
        .act_wr_tim (act_wr_tim),
        .act_misc   (act_misc)
    );

endmodule

// File: tb/tb_cfg_window_top.sv
module tb_cfg_window_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic       acc_word = 1'b0;
    logic [2:0] acc_off = '0;
    logic [7:0] acc_wdata = '0;
    logic       strap_clk25 = 1'b0;
    logic       drive_sel = 1'b0;
    logic [7:0] rd_data, act_rd_tim, act_wr_tim, act_misc;
    logic       rd_hit, win_open;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference state built from the requirements
    bit       m_open, m_setb;
    int       m_seq;
    bit [7:0] m_rd [2];
    bit [7:0] m_wr [2];
    bit [7:0] m_ctrl, m_misc;

    always #2.5 clk = ~clk;

    cfg_window_top dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_word(acc_word), .acc_off(acc_off), .acc_wdata(acc_wdata),
        .strap_clk25(strap_clk25), .drive_sel(drive_sel), .rd_data(rd_data),
        .rd_hit(rd_hit), .win_open(win_open), .act_rd_tim(act_rd_tim),
        .act_wr_tim(act_wr_tim), .act_misc(act_misc)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int m_idx();
        return (m_setb && m_misc[0]) ? 1 : 0;
    endfunction

    function automatic bit exp_hit(bit [2:0] off);
        return m_open && (off inside {3'd0, 3'd1, 3'd3, 3'd5, 3'd6});
    endfunction

    function automatic bit [7:0] exp_rdata(bit [2:0] off);
        if (!exp_hit(off)) return 8'h00;
        case (off)
            3'd0:    return m_rd[m_idx()];
            3'd1:    return m_wr[m_idx()];
            3'd3:    return m_ctrl;
            3'd5:    return {7'b0, strap_clk25};
            default: return m_misc;
        endcase
    endfunction

    function automatic void m_step(bit wr, bit wd, bit [2:0] off, bit [7:0] d);
        bit probe = !wr && wd && off == 3'd1;
        if (m_open) begin
            if (wr) begin
                case (off)
                    3'd0: m_rd[m_idx()] = d;
                    3'd1: m_wr[m_idx()] = d;
                    3'd3: m_ctrl = d;
                    3'd6: m_misc = d;
                    3'd2: if (!wd && d == 8'h83) m_open = 1'b0;
                    default: ;
                endcase
            end
        end else begin
            if (wr && !wd && off == 3'd3 && d == 8'hC0) m_setb = 1'b1;
            if (m_seq == 2 && wr && !wd && off == 3'd2 && d == 8'h03) begin
                m_open = 1'b1;
                m_seq = 0;
            end else if (probe && m_seq < 2) m_seq = m_seq + 1;
            else m_seq = 0;
        end
    endfunction

    task automatic check_state(input string tag);
        int s = (m_ctrl[0] && drive_sel) ? 1 : 0;
        chk({tag, " win_open"}, int'(win_open), int'(m_open));
        chk({tag, " R10 act_rd_tim"}, int'(act_rd_tim), int'(m_rd[s]));
        chk({tag, " R10 act_wr_tim"}, int'(act_wr_tim), int'(m_wr[s]));
        chk({tag, " R10 act_misc"}, int'(act_misc), int'(m_misc));
    endtask

    task automatic acc(input bit wr, input bit wd, input bit [2:0] off,
                       input bit [7:0] d, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_word = wd;
        acc_off = off; acc_wdata = d;
        #1;
        if (!wr) begin
            chk({tag, " rd_hit"}, int'(rd_hit), int'(exp_hit(off)));
            chk({tag, " rd_data"}, int'(rd_data), int'(exp_rdata(off)));
        end
        @(posedge clk);
        m_step(wr, wd, off, d);
        @(negedge clk);
        acc_valid = 1'b0;
        #1;
        check_state(tag);
    endtask

    task automatic unlock(input string tag);
        acc(0, 1, 3'd1, 8'h00, tag);
        acc(0, 1, 3'd1, 8'h00, tag);
        acc(1, 0, 3'd2, 8'h03, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20417));
        m_open = 0; m_setb = 0; m_seq = 0; m_ctrl = 0; m_misc = 0;
        for (int i = 0; i < 2; i++) begin m_rd[i] = 8'hFF; m_wr[i] = 8'hFF; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check_state("R11 reset");

        // R4: closed window claims nothing and stores nothing
        acc(0, 0, 3'd0, 8'h00, "R4 closed read");
        acc(1, 0, 3'd0, 8'h12, "R4 closed write");
        // R2: broken sequences
        acc(0, 1, 3'd1, 8'h00, "R2 a");
        acc(0, 0, 3'd1, 8'h00, "R2 byte read");
        acc(1, 0, 3'd2, 8'h03, "R2 no open after byte read");
        acc(0, 1, 3'd1, 8'h00, "R2 b");
        acc(0, 1, 3'd1, 8'h00, "R2 b");
        acc(0, 1, 3'd1, 8'h00, "R2 third read");
        acc(1, 0, 3'd2, 8'h03, "R2 no open after three reads");
        chk("R2 still closed", int'(win_open), 0);
        // R1: proper unlock
        unlock("R1 unlock");
        chk("R1 window open", int'(win_open), 1);
        acc(0, 0, 3'd0, 8'h00, "R4 R11 closed write left set A");
        // R5 register map
        acc(1, 0, 3'd0, 8'h5B, "R5 write rd tim");
        acc(1, 1, 3'd1, 8'h45, "R5 word write wr tim");
        acc(0, 0, 3'd0, 8'h00, "R5 read rd tim");
        acc(0, 0, 3'd1, 8'h00, "R5 read wr tim");
        acc(0, 0, 3'd4, 8'h00, "R5 unmapped");
        // R6 strap
        strap_clk25 = 1'b1;
        acc(0, 0, 3'd5, 8'h00, "R6 strap 25MHz");
        strap_clk25 = 1'b0;
        acc(0, 0, 3'd5, 8'h00, "R6 strap 33MHz");
        acc(1, 0, 3'd5, 8'hAA, "R6 strap write");
        acc(0, 0, 3'd5, 8'h00, "R6 strap after write");
        // R8: set B locked, index 1 reaches A
        acc(1, 0, 3'd6, 8'h01, "R8 misc idx1");
        acc(1, 0, 3'd0, 8'h11, "R8 write goes to A");
        acc(0, 0, 3'd0, 8'h00, "R8 read A");
        // R3 close behaviour
        acc(1, 0, 3'd2, 8'h55, "R3 other key keeps open");
        acc(1, 0, 3'd2, 8'h83, "R3 close");
        // R8 enable B, then R7 index steering
        acc(1, 0, 3'd3, 8'hC0, "R8 enable set B");
        unlock("R1 reopen");
        acc(1, 0, 3'd0, 8'h22, "R7 write set B");
        acc(1, 0, 3'd1, 8'h33, "R7 write set B");
        acc(1, 0, 3'd6, 8'h00, "R7 misc idx0");
        acc(0, 0, 3'd0, 8'h00, "R7 read set A");
        // R9 drive assignment
        acc(1, 0, 3'd3, 8'h85, "R9 per-drive");
        drive_sel = 1'b1; #1; check_state("R9 drive1 set B");
        drive_sel = 1'b0; #1; check_state("R9 drive0 set A");
        acc(1, 0, 3'd3, 8'h84, "R9 shared");
        drive_sel = 1'b1; #1; check_state("R9 drive1 shared A");

        // random streams with frequent unlock and close keys
        for (int n = 0; n < 3000; n++) begin
            int k = $urandom_range(0, 15);
            drive_sel = 1'($urandom_range(0, 1));
            strap_clk25 = 1'($urandom_range(0, 1));
            if (k == 0) unlock("R1 rand unlock");
            else if (k == 1) acc(1, 0, 3'd2, 8'h83, "R3 rand close");
            else if (k == 2) acc(0, 1, 3'd1, 8'h00, "R2 rand probe");
            else if (k == 3) acc(1, 0, 3'd2, 8'h03, "R2 rand key");
            else acc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     3'($urandom_range(0, 7)), 8'($urandom_range(0, 255)),
                     "R5 rand");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule